// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits in the decode stage of an in-order core that can issue two instructions per cycle into two unequal pipes, called U and V. Each cycle it looks at the two oldest decoded instructions, the older slot and the younger slot. It decides whether both instructions can issue together, or whether only the older one issues. When only the older one issues, the younger instruction moves into the older slot on the next cycle; the logic that does this shift is outside the block.

Several things stop two instructions from pairing. The younger instruction may read a byte lane that the older one writes. Both instructions may write the same register, and this counts even when they write different byte lanes. Either instruction may belong to a class that always issues alone. The two classes may not fit the pipe rules. The older instruction normally takes the U pipe. A branch in the older slot can only run in V, so it issues alone and is sent to V.

The decision is held in registers. It appears on the outputs one clock edge after the inputs are sampled.

Top module: `dual_issue_pair_check`

## Requirements
- R1: The two issue outputs are mutually exclusive. One edge after sampling an older slot that is valid, exactly one of them is high. When the older slot is invalid, both are low and the younger slot never issues.
- R2: While `rst_n` is low at a clock edge, all three outputs are cleared to 0.
- R3: The pair is split (issue_first_only) when the older slot writes a register and the younger slot reads that register through a source whose use bit is set, and the byte lanes overlap. Lane codes select bytes of the 32-bit register: 0 selects all four bytes, 1 selects bytes 0–1, 2 selects byte 0, 3 selects byte 1. A source whose use bit is clear, or an older slot whose write enable is clear, does not split the pair.
- R4: A read of byte 1 after a write to byte 0 of the same register does not block pairing.
- R5: The pair is split when both slots write the same register, whatever the lanes, including low byte against high byte. A younger slot whose write enable is clear does not split the pair.
- R6: The pair is split when either slot has its never-pair flag set, or has class 6 (multiply, divide, push-all, string move) or class 7 (other unpairable).
- R7: An older slot of class 5 (jump, conditional jump, call) issues alone with `first_in_v` = 1.
- R8: A younger slot of class 4 (shift or rotate, U pipe only) splits the pair.
- R9: In every other case with both slots valid, the block issues both, with `first_in_v` = 0. The older slot goes to U and the younger to V. This covers classes 0 (move), 1 (simple ALU), 2 (push/pop), 3 (compare/test), 4 (in the older slot) and 5 (in the younger slot).
- R10: Outputs change only at the clock edge that follows the sampling of the inputs. Between edges they keep the previous decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| old_valid | input | 1 | Older slot holds an instruction |
| old_class | input | 3 | Older slot class code |
| old_never | input | 1 | Older slot never-pair flag |
| old_dst | input | REG_W | Older slot destination register |
| old_dst_lane | input | 2 | Older slot destination lane code |
| old_dst_we | input | 1 | Older slot writes its destination |
| yng_valid | input | 1 | Younger slot holds an instruction |
| yng_class | input | 3 | Younger slot class code |
| yng_never | input | 1 | Younger slot never-pair flag |
| yng_src | input | NSRC*REG_W | Younger slot source registers, source 0 in the low bits |
| yng_src_lane | input | NSRC*2 | Younger slot source lane codes |
| yng_src_use | input | NSRC | Younger slot source-in-use bits |
| yng_dst | input | REG_W | Younger slot destination register |
| yng_dst_we | input | 1 | Younger slot writes its destination |
| issue_both | output | 1 | Both slots issue this cycle |
| issue_first_only | output | 1 | Only the older slot issues |
| first_in_v | output | 1 | Older slot is sent to the V pipe |

## Verification
A single pair of slots can meet a pipe-class restriction and a register hazard at the same time. For example, a younger shift can also read the older slot's destination, or an older branch can share a destination with the younger slot. The sweep provokes these overlaps by crossing all 64 class pairs with every dependence and flag pattern. For each combination it computes the expected outcome from the rules. Where several rules apply, the check credits the rule that takes priority, and branch routing to V is judged separately from the split decision.

// File: rtl/pair_pkg.sv
// Package: shared class codes, lane codes and lane-to-byte mapping for the
// dual-issue pairing check. Assumes 32-bit architectural registers split
// into four byte positions.
package pair_pkg;

    localparam int CLASS_W = 3;
    localparam int LANE_W  = 2;
    localparam int BYTES_W = 4;

    typedef enum logic [CLASS_W-1:0] {
        CL_MOVE    = 3'd0,
        CL_ALU     = 3'd1,
        CL_STACK   = 3'd2,
        CL_CMP     = 3'd3,
        CL_SHIFT   = 3'd4,
        CL_BRANCH  = 3'd5,
        CL_COMPLEX = 3'd6,
        CL_MISC    = 3'd7
    } insn_class_e;

    localparam logic [LANE_W-1:0] LN_FULL  = 2'd0;
    localparam logic [LANE_W-1:0] LN_HALF  = 2'd1;
    localparam logic [LANE_W-1:0] LN_BYTE0 = 2'd2;
    localparam logic [LANE_W-1:0] LN_BYTE1 = 2'd3;

    // Map a lane code to the set of register bytes it touches.
    function automatic logic [BYTES_W-1:0] lane_bytes(input logic [LANE_W-1:0] ln);
        case (ln)
            LN_FULL:  lane_bytes = 4'b1111;
            LN_HALF:  lane_bytes = 4'b0011;
            LN_BYTE0: lane_bytes = 4'b0001;
            default:  lane_bytes = 4'b0010;
        endcase
    endfunction

endpackage

// File: rtl/pair_class_rules.sv
// Module: per-slot class screening. For each of the two slots it flags
// classes that never pair, and it flags the class-to-pipe restrictions that
// matter to the pairing choice (older slot V-only, younger slot U-only).
// Assumes class codes from pair_pkg; purely combinational.
module pair_class_rules
    import pair_pkg::*;
(
    input  logic [CLASS_W-1:0] old_class,
    input  logic               old_never,
    input  logic [CLASS_W-1:0] yng_class,
    input  logic               yng_never,
    output logic               old_v_only,
    output logic               yng_u_only,
    output logic               old_no_pair,
    output logic               yng_no_pair
);

    localparam int NSLOT = 2;

    logic [NSLOT-1:0][CLASS_W-1:0] cls;
    logic [NSLOT-1:0]              flag;
    logic [NSLOT-1:0]              solo;
    logic [NSLOT-1:0]              u_only;
    logic [NSLOT-1:0]              v_only;

    // Gather both slots into arrays so the screen is built once per slot.
    always_comb begin
        cls[0]  = old_class;
        cls[1]  = yng_class;
        flag[0] = old_never;
        flag[1] = yng_never;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Classify one slot: solo-only classes, U-only and V-only classes.
        always_comb begin
            solo[s]   = flag[s] || (cls[s] == CL_COMPLEX) || (cls[s] == CL_MISC);
            u_only[s] = (cls[s] == CL_SHIFT);
            v_only[s] = (cls[s] == CL_BRANCH);
        end
    end

    // Expose only the restrictions the issue choice consumes.
    always_comb begin
        old_v_only  = v_only[0];
        yng_u_only  = u_only[1];
        old_no_pair = solo[0];
        yng_no_pair = solo[1];
    end

endmodule

// File: rtl/pair_dep_check.sv
// Module: register dependence detection between the older and younger slot.
// Flags a flow dependence when any used younger source names the older
// destination with overlapping bytes, and an output dependence whenever
// both slots write the same register regardless of lanes. Combinational.
module pair_dep_check
    import pair_pkg::*;
#(
    parameter int REG_W = 3,
    parameter int NSRC  = 2
) (
    input  logic [REG_W-1:0]        old_dst,
    input  logic [LANE_W-1:0]       old_dst_lane,
    input  logic                    old_dst_we,
    input  logic [NSRC*REG_W-1:0]   yng_src,
    input  logic [NSRC*LANE_W-1:0]  yng_src_lane,
    input  logic [NSRC-1:0]         yng_src_use,
    input  logic [REG_W-1:0]        yng_dst,
    input  logic                    yng_dst_we,
    output logic                    raw_hit,
    output logic                    waw_hit
);

    logic [BYTES_W-1:0] old_bytes;
    logic [NSRC-1:0]    src_hit;

    // Bytes of the older destination that the write touches.
    always_comb old_bytes = lane_bytes(old_dst_lane);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [REG_W-1:0]   sreg;
        logic [BYTES_W-1:0] sbytes;
        // Compare one younger source against the older write.
        always_comb begin
            sreg       = yng_src[i*REG_W +: REG_W];
            sbytes     = lane_bytes(yng_src_lane[i*LANE_W +: LANE_W]);
            src_hit[i] = yng_src_use[i] && old_dst_we && (sreg == old_dst)
                         && ((sbytes & old_bytes) != '0);
        end
    end

    // Reduce per-source hits and detect a shared destination.
    always_comb begin
        raw_hit = |src_hit;
        waw_hit = old_dst_we && yng_dst_we && (old_dst == yng_dst);
    end

endmodule

// File: rtl/pair_issue_ctrl.sv
// Module: issue choice and output registers. Combines slot validity, class
// screening and dependence hits into one of: issue both, issue older only,
// or nothing, plus the pipe of the older slot. Decisions are registered;
// synchronous active-low reset clears them.
module pair_issue_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic old_valid,
    input  logic yng_valid,
    input  logic old_v_only,
    input  logic yng_u_only,
    input  logic old_no_pair,
    input  logic yng_no_pair,
    input  logic raw_hit,
    input  logic waw_hit,
    output logic issue_both,
    output logic issue_first_only,
    output logic first_in_v
);

    logic pair_ok;
    logic both_d;
    logic first_d;
    logic vpipe_d;

    // Decide for this cycle from all blocking conditions.
    always_comb begin
        pair_ok = old_valid && yng_valid && !old_v_only && !yng_u_only
                  && !old_no_pair && !yng_no_pair && !raw_hit && !waw_hit;
        both_d  = pair_ok;
        first_d = old_valid && !pair_ok;
        vpipe_d = old_valid && old_v_only;
    end

    // Hold the decision for the issue stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_both       <= 1'b0;
            issue_first_only <= 1'b0;
            first_in_v       <= 1'b0;
        end else begin
            issue_both       <= both_d;
            issue_first_only <= first_d;
            first_in_v       <= vpipe_d;
        end
    end

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_both && issue_first_only)); // R1
    AST_OLDER_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        old_valid |=> (issue_both || issue_first_only)); // R1
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !old_valid |=> !(issue_both || issue_first_only)); // R1
    AST_RAW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && yng_valid && raw_hit) |=> (issue_first_only && !issue_both)); // R3
    AST_WAW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && yng_valid && waw_hit) |=> (issue_first_only && !issue_both)); // R5
    AST_SOLO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && (old_no_pair || yng_no_pair)) |=> !issue_both); // R6
    AST_BRANCH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && old_v_only) |=> (issue_first_only && first_in_v)); // R7
    AST_SHIFT_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && yng_u_only) |=> !issue_both); // R8
    AST_PAIR_IN_U: assert property (@(posedge clk) disable iff (!rst_n)
        issue_both |-> !first_in_v); // R9

endmodule

// File: rtl/dual_issue_pair_check.sv
// Module: top of the dual-issue pairing check. Wires class screening and
// dependence detection into the registered issue choice. Assumes the slots
// are presented in program order and that a separate stage shifts the
// younger slot forward when only the older one issues.
module dual_issue_pair_check
    import pair_pkg::*;
#(
    parameter int REG_W = 3,
    parameter int NSRC  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   old_valid,
    input  logic [2:0]             old_class,
    input  logic                   old_never,
    input  logic [REG_W-1:0]       old_dst,
    input  logic [1:0]             old_dst_lane,
    input  logic                   old_dst_we,
    input  logic                   yng_valid,
    input  logic [2:0]             yng_class,
    input  logic                   yng_never,
    input  logic [NSRC*REG_W-1:0]  yng_src,
    input  logic [NSRC*2-1:0]      yng_src_lane,
    input  logic [NSRC-1:0]        yng_src_use,
    input  logic [REG_W-1:0]       yng_dst,
    input  logic                   yng_dst_we,
    output logic                   issue_both,
    output logic                   issue_first_only,
    output logic                   first_in_v
);

    logic old_v_only;
    logic yng_u_only;
    logic old_no_pair;
    logic yng_no_pair;
    logic raw_hit;
    logic waw_hit;

    pair_class_rules u_rules (
        .old_class   (old_class),
        .old_never   (old_never),
        .yng_class   (yng_class),
        .yng_never   (yng_never),
        .old_v_only  (old_v_only),
        .yng_u_only  (yng_u_only),
        .old_no_pair (old_no_pair),
        .yng_no_pair (yng_no_pair)
    );

    pair_dep_check #(
        .REG_W (REG_W),
        .NSRC  (NSRC)
    ) u_dep (
        .old_dst      (old_dst),
        .old_dst_lane (old_dst_lane),
        .old_dst_we   (old_dst_we),
        .yng_src      (yng_src),
        .yng_src_lane (yng_src_lane),
        .yng_src_use  (yng_src_use),
        .yng_dst      (yng_dst),
        .yng_dst_we   (yng_dst_we),
        .raw_hit      (raw_hit),
        .waw_hit      (waw_hit)
    );

    pair_issue_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .old_valid        (old_valid),
        .yng_valid        (yng_valid),
        .old_v_only       (old_v_only),
        .yng_u_only       (yng_u_only),
        .old_no_pair      (old_no_pair),
        .yng_no_pair      (yng_no_pair),
        .raw_hit          (raw_hit),
        .waw_hit          (waw_hit),
        .issue_both       (issue_both),
        .issue_first_only (issue_first_only),
        .first_in_v       (first_in_v)
    );

endmodule

// File: tb/dual_issue_pair_check_tb.sv
// Bench: sweeps every class pair against every dependence and flag pattern
// and compares the registered decision with values worked out from the rules.
module dual_issue_pair_check_tb;

    localparam int REG_W = 3;
    localparam int NSRC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic old_valid = 0, old_never = 0, old_dst_we = 0;
    logic [2:0] old_class = 0;
    logic [REG_W-1:0] old_dst = 0;
    logic [1:0] old_dst_lane = 0;
    logic yng_valid = 0, yng_never = 0, yng_dst_we = 0;
    logic [2:0] yng_class = 0;
    logic [NSRC*REG_W-1:0] yng_src = 0;
    logic [NSRC*2-1:0] yng_src_lane = 0;
    logic [NSRC-1:0] yng_src_use = 0;
    logic [REG_W-1:0] yng_dst = 0;
    logic issue_both, issue_first_only, first_in_v;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dual_issue_pair_check #(.REG_W(REG_W), .NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .old_valid(old_valid), .old_class(old_class), .old_never(old_never),
        .old_dst(old_dst), .old_dst_lane(old_dst_lane), .old_dst_we(old_dst_we),
        .yng_valid(yng_valid), .yng_class(yng_class), .yng_never(yng_never),
        .yng_src(yng_src), .yng_src_lane(yng_src_lane), .yng_src_use(yng_src_use),
        .yng_dst(yng_dst), .yng_dst_we(yng_dst_we),
        .issue_both(issue_both), .issue_first_only(issue_first_only),
        .first_in_v(first_in_v)
    );

    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {issue_both, issue_first_only, first_in_v};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {both,first,v} actual=%b expected=%b (old=%0d yng=%0d)",
                     tag, act, exp, old_class, yng_class);
        end
    endtask

    // Kinds: 0 none, 1 raw full, 2 raw half/byte0, 3 byte0 vs byte1 read,
    // 4 matching source unused, 5 older not writing, 6 waw same lane,
    // 7 waw byte0 vs byte1, 8 younger not writing, 9 older never flag,
    // 10 younger never flag, 11 older invalid, 12 younger invalid.
    task automatic set_case(input int ac, input int bc, input int kind);
        old_valid = (kind != 11);  yng_valid = (kind != 12);
        old_class = 3'(ac);        yng_class = 3'(bc);
        old_never = (kind == 9);   yng_never = (kind == 10);
        old_dst = 3'd1; old_dst_lane = 2'd0; old_dst_we = (kind != 5);
        yng_src = {3'd3, 3'd2}; yng_src_lane = 4'b0000; yng_src_use = 2'b11;
        yng_dst = 3'd4; yng_dst_we = 1'b1;
        case (kind)
            1: yng_src[2:0] = 3'd1;
            2: begin old_dst_lane = 2'd1; yng_src[5:3] = 3'd1; yng_src_lane[3:2] = 2'd2; end
            3: begin old_dst_lane = 2'd2; yng_src[2:0] = 3'd1; yng_src_lane[1:0] = 2'd3; end
            4: begin yng_src[2:0] = 3'd1; yng_src_use = 2'b10; end
            5: yng_src[2:0] = 3'd1;
            6: yng_dst = 3'd1;
            7: begin old_dst_lane = 2'd2; yng_dst = 3'd1; end
            8: begin yng_dst = 3'd1; yng_dst_we = 1'b0; end
            default: ;
        endcase
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R2: reset with a pairable stimulus present still clears outputs
        set_case(0, 1, 0);
        repeat (3) @(negedge clk);
        chk("R2", 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", 3'b100);

        // R10: change inputs to a split case; value holds until the edge
        set_case(0, 1, 6);
        #1 chk("R10", 3'b100);
        @(negedge clk);
        chk("R10", 3'b010);

        for (int ac = 0; ac < 8; ac++) begin
            for (int bc = 0; bc < 8; bc++) begin
                for (int kind = 0; kind < 13; kind++) begin
                    logic av, bv, blocked, na, nb, eb, ef, ev;
                    string tag;
                    set_case(ac, bc, kind);
                    av = (kind != 11);
                    bv = (kind != 12);
                    blocked = (kind == 1) || (kind == 2) || (kind == 6) || (kind == 7);
                    na = (kind == 9) || (ac >= 6);
                    nb = (kind == 10) || (bc >= 6);
                    eb = av && bv && (ac != 5) && (bc != 4) && !na && !nb && !blocked;
                    ef = av && !eb;
                    ev = av && (ac == 5);
                    if (!av) tag = "R1";
                    else if (ac == 5) tag = "R7";
                    else if (!bv) tag = "R1";
                    else if (na || nb) tag = "R6";
                    else if (bc == 4) tag = "R8";
                    else if (kind == 1 || kind == 2 || kind == 4 || kind == 5) tag = "R3";
                    else if (kind == 3) tag = "R4";
                    else if (kind >= 6 && kind <= 8) tag = "R5";
                    else tag = "R9";
                    @(negedge clk);
                    chk(tag, {eb, ef, ev});
                end
            end
        end

        // R2: reset asserted mid-stream clears a held decision
        set_case(5, 0, 0);
        @(negedge clk);
        chk("R7", 3'b011);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2", 3'b000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule